// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Byte-Count Read Select

This block is a small direct-mapped data cache for one CPU port. It holds eight lines, each made of four 32-bit words, a tag and a valid flag. A write stores one 32-bit word into the line picked by the set field of the address and takes over the line's tag. If the line was empty or held another tag, the other three words are cleared.

A read checks the line's tag and valid flag. One cycle later it returns a hit flag and a right-justified slice of one to four bytes from the addressed word. The slice starts at the byte offset in the address. Its length comes from a 2-bit size code, and it is cut short at the end of the word. Missing reads and idle cycles return zero data with the hit flag low.

Top module: `dm_cache_sizesel`

## Requirements
- R1: After a synchronous reset every line is invalid, so every read misses until a line is written; during reset `hit_o` is 0 and `rdata_o` is 0.
- R2: Address fields: bits [1:0] are the byte offset, bits [3:2] pick the word in the line, bit 4 is ignored, bits [7:5] pick the set and bits [31:8] are the tag. A write enables at most one line.
- R3: A read hits only when the line is valid and its stored tag equals the address tag. On a miss, `hit_o` is 0 and `rdata_o` is 0.
- R4: A write to a valid line whose tag equals the address tag replaces only the addressed word. The other words stay as they were, and a following read of the same address hits.
- R5: A write to an invalid line, or to a line holding another tag, stores the new tag, sets valid, loads the addressed word and clears the other three words to zero.
- R6: Size code 0, 1, 2 and 3 asks for 1, 2, 3 and 4 bytes. Byte k of a word is bits [8k+7:8k]. The returned bytes sit from bit 0 upward, and all higher output bytes are zero.
- R7: The first returned byte is the byte at the address offset, followed by the next higher bytes. The count is limited to the bytes left before the end of the word, so offset 2 with code 3 returns two bytes.
- R8: A read sampled at a rising edge is reported on `hit_o`/`rdata_o` from that edge until the next one. A cycle without `rd_en_i` gives `hit_o` 0 and `rdata_o` 0.
- R9: When read and write are requested in the same cycle, the read result reflects the line contents before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 32 | Byte address for both read and write |
| wdata_i | input | 32 | Word to store on a write |
| wr_en_i | input | 1 | Write request |
| rd_en_i | input | 1 | Read request |
| size_i | input | 2 | Byte-count code for reads |
| hit_o | output | 1 | Registered hit flag of the last read |
| rdata_o | output | 32 | Registered right-justified read bytes |

## Verification
The assertions take for granted that all inputs are driven to known values from time zero and that `addr_i` is held with its request for the whole cycle. The write-visibility property also assumes that a read of a just-written address is not itself paired with another write. The bench changes inputs only on falling edges, holds every control low through reset, and puts the combined read-and-write case in a directed step of its own. Every 2-bit size code is legal, so no size value lies outside the checked space.

// File: rtl/dmc_pkg.sv
// Package: shared types for the direct-mapped size-select cache.
// Assumes: byte-addressed words; size code counts bytes minus one.
package dmc_pkg;

    // Byte-count request encoding seen on the size input
    typedef enum logic [1:0] {
        SZ_ONE   = 2'd0,
        SZ_TWO   = 2'd1,
        SZ_THREE = 2'd2,
        SZ_FOUR  = 2'd3
    } size_code_e;

    // Number of bytes a size code asks for
    function automatic int req_bytes(input logic [1:0] code);
        return int'(code) + 1;
    endfunction

endpackage

// File: rtl/dmc_addr_fields.sv
// Module: splits a CPU byte address into offset, word, set and tag fields.
// Assumes: one reserved bit sits between the word field and the set field;
// the tag is everything above the set field.
module dmc_addr_fields #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2,
    parameter int WSEL_W = 2,
    parameter int RSV_W  = 1,
    parameter int SET_W  = 3,
    parameter int TAG_W  = ADDR_W - OFF_W - WSEL_W - RSV_W - SET_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [OFF_W-1:0]  off,
    output logic [WSEL_W-1:0] wsel,
    output logic [SET_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  tag
);
    localparam int SET_LO = OFF_W + WSEL_W + RSV_W;
    localparam int TAG_LO = SET_LO + SET_W;

    // Field extraction; the reserved bit is dropped by the shifts
    assign off     = addr[OFF_W-1:0];
    assign wsel    = addr[OFF_W +: WSEL_W];
    assign set_idx = SET_W'(addr >> SET_LO);
    assign tag     = TAG_W'(addr >> TAG_LO);

endmodule

// File: rtl/dmc_line_store.sv
// Module: line storage (valid, tag, words) with single-word writes and a
// combinational lookup of one line. Assumes write and lookup use the same
// address, and the lookup sees state before the write at the same edge.
module dmc_line_store #(
    parameter int SETS   = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 24,
    parameter int SET_W  = $clog2(SETS),
    parameter int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  set_idx,
    input  logic [WSEL_W-1:0] wsel,
    input  logic [TAG_W-1:0]  tag,
    input  logic [DATA_W-1:0] wr_data,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_word
);
    logic [SETS-1:0]   line_we;
    logic [SETS-1:0]   valid_vec;
    logic [TAG_W-1:0]  tag_arr  [SETS];
    logic [DATA_W-1:0] word_arr [SETS][WORDS];

    genvar s, w;
    generate
        for (s = 0; s < SETS; s++) begin : g_line
            logic              v_q;
            logic [TAG_W-1:0]  t_q;
            logic [DATA_W-1:0] d_q [WORDS];
            logic              replace;

            // Set decoder: one write enable per line
            assign line_we[s] = wr_en && (set_idx == SET_W'(s));
            // New tag or empty line means the whole line is taken over
            assign replace = !v_q || (t_q != tag);

            // Valid flag: cleared by reset, set by any write to this line
            always_ff @(posedge clk) begin
                if (!rst_n)          v_q <= 1'b0;
                else if (line_we[s]) v_q <= 1'b1;
            end

            // Tag and words: load addressed word, clear others on takeover
            always_ff @(posedge clk) begin
                if (line_we[s]) begin
                    t_q <= tag;
                    for (int k = 0; k < WORDS; k++) begin
                        if (k == int'(wsel)) d_q[k] <= wr_data;
                        else if (replace)    d_q[k] <= '0;
                    end
                end
            end

            assign valid_vec[s] = v_q;
            assign tag_arr[s]   = t_q;
            for (w = 0; w < WORDS; w++) begin : g_word
                assign word_arr[s][w] = d_q[w];
            end
        end
    endgenerate

    // Lookup of the addressed line and word
    always_comb begin
        look_hit  = valid_vec[set_idx] && (tag_arr[set_idx] == tag);
        look_word = word_arr[set_idx][wsel];
    end

    AST_SINGLE_LINE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(line_we)); // R2

endmodule

// File: rtl/dmc_byte_slicer.sv
// Module: picks a right-justified run of bytes out of a word, starting at a
// byte offset, length from a size code, truncated at the word's top byte.
// Assumes byte k of the word is bits [8k+7:8k].
module dmc_byte_slicer #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = $clog2(DATA_W / 8)
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] slice_out
);
    import dmc_pkg::*;

    localparam int BYTES = DATA_W / 8;

    logic [BYTES-1:0] byte_mask;

    // Byte selection: count = min(requested, bytes left in word)
    always_comb begin
        int avail;
        int want;
        int cnt;
        avail     = BYTES - int'(off);
        want      = req_bytes(size);
        cnt       = (want < avail) ? want : avail;
        slice_out = '0;
        byte_mask = '0;
        for (int b = 0; b < BYTES; b++) begin
            if (b < cnt) begin
                slice_out[8*b +: 8] = word_in[8*(b + int'(off)) +: 8];
                byte_mask[b]        = 1'b1;
            end
        end
    end

    // Mask never exceeds the requested count
    always_comb begin
        AST_SLICE_WIDTH: assert ($countones(byte_mask) <= req_bytes(size)); // R7
    end

endmodule

// File: rtl/dm_cache_sizesel.sv
// Module: top of the direct-mapped cache. Samples read/write at the rising
// edge and registers hit and sliced data with one cycle of latency.
// Assumes a single shared address; a read paired with a write sees the
// line before that write.
module dm_cache_sizesel #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 8,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [1:0]        size_i,
    output logic              hit_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int OFF_W  = $clog2(DATA_W / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int RSV_W  = 1;
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - WSEL_W - RSV_W - SET_W;

    logic [OFF_W-1:0]  off;
    logic [WSEL_W-1:0] wsel;
    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  tag;
    logic              look_hit;
    logic [DATA_W-1:0] look_word;
    logic [DATA_W-1:0] slice;
    logic              hit_q;
    logic [DATA_W-1:0] data_q;

    dmc_addr_fields #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WSEL_W(WSEL_W),
        .RSV_W(RSV_W), .SET_W(SET_W), .TAG_W(TAG_W)
    ) u_fields (
        .addr(addr_i), .off(off), .wsel(wsel), .set_idx(set_idx), .tag(tag)
    );

    dmc_line_store #(
        .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W),
        .SET_W(SET_W), .WSEL_W(WSEL_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .set_idx(set_idx),
        .wsel(wsel), .tag(tag), .wr_data(wdata_i),
        .look_hit(look_hit), .look_word(look_word)
    );

    dmc_byte_slicer #(
        .DATA_W(DATA_W), .OFF_W(OFF_W)
    ) u_slice (
        .word_in(look_word), .off(off), .size(size_i), .slice_out(slice)
    );

    // Output register: quiet on reset, idle or miss
    always_ff @(posedge clk) begin
        if (!rst_n || !rd_en_i) begin
            hit_q  <= 1'b0;
            data_q <= '0;
        end else begin
            hit_q  <= look_hit;
            data_q <= look_hit ? slice : '0;
        end
    end

    assign hit_o   = hit_q;
    assign rdata_o = data_q;

    AST_RESET_MISS: assert property (@(posedge clk) disable iff (!rst_n) $past(!rst_n) |-> (!hit_o && rdata_o == '0)); // R1
    AST_MISS_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !hit_o |-> (rdata_o == '0)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !rd_en_i |=> (!hit_o && rdata_o == '0)); // R8
    AST_SIZE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rd_en_i |=> ((rdata_o >> (8 * (int'($past(size_i)) + 1))) == '0)); // R6
    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $past(wr_en_i) && rd_en_i && !wr_en_i && addr_i == $past(addr_i)) |=> hit_o); // R4

endmodule

// File: tb/dm_cache_sizesel_test.sv
// Bench: vector table walked by one loop, then directed reset and
// same-cycle read/write cases. Inputs change on falling edges.
module dm_cache_sizesel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  size = 2'd0;
    logic        hit;
    logic [31:0] rdata;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk; // 125 MHz

    dm_cache_sizesel uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .size_i(size),
        .hit_o(hit), .rdata_o(rdata)
    );

    // {op[2], addr[32], wdata[32], size[2], exp_hit, exp_data[32]}; op 0 idle, 1 write, 2 read
    localparam int NV = 24;
    localparam logic [100:0] VEC [NV] = '{
        {2'd2, 32'h000, 32'h0,        2'd3, 1'b0, 32'h0},        // R1 empty cache
        {2'd1, 32'h100, 32'h11223344, 2'd0, 1'b0, 32'h0},        // R8 write gives no read
        {2'd2, 32'h100, 32'h0,        2'd3, 1'b1, 32'h11223344}, // R4
        {2'd2, 32'h101, 32'h0,        2'd0, 1'b1, 32'h00000033}, // R6
        {2'd2, 32'h100, 32'h0,        2'd1, 1'b1, 32'h00003344}, // R6
        {2'd2, 32'h100, 32'h0,        2'd2, 1'b1, 32'h00223344}, // R6
        {2'd2, 32'h101, 32'h0,        2'd2, 1'b1, 32'h00112233}, // R7
        {2'd2, 32'h102, 32'h0,        2'd3, 1'b1, 32'h00001122}, // R7 truncated
        {2'd2, 32'h103, 32'h0,        2'd1, 1'b1, 32'h00000011}, // R7 truncated
        {2'd1, 32'h104, 32'hAABBCCDD, 2'd0, 1'b0, 32'h0},        // R4
        {2'd2, 32'h104, 32'h0,        2'd3, 1'b1, 32'hAABBCCDD}, // R4
        {2'd2, 32'h100, 32'h0,        2'd3, 1'b1, 32'h11223344}, // R4 other word kept
        {2'd2, 32'h200, 32'h0,        2'd3, 1'b0, 32'h0},        // R3 tag mismatch
        {2'd1, 32'h208, 32'hCAFEF00D, 2'd0, 1'b0, 32'h0},        // R5
        {2'd2, 32'h208, 32'h0,        2'd3, 1'b1, 32'hCAFEF00D}, // R5
        {2'd2, 32'h200, 32'h0,        2'd3, 1'b1, 32'h0},        // R5 cleared word
        {2'd2, 32'h104, 32'h0,        2'd3, 1'b0, 32'h0},        // R5 old tag gone
        {2'd1, 32'h1AC, 32'h0F1E2D3C, 2'd0, 1'b0, 32'h0},        // R2 set 5 word 3
        {2'd2, 32'h1AE, 32'h0,        2'd0, 1'b1, 32'h0000001E}, // R2 offset field
        {2'd2, 32'h1BC, 32'h0,        2'd3, 1'b1, 32'h0F1E2D3C}, // R2 bit 4 ignored
        {2'd2, 32'h1A0, 32'h0,        2'd3, 1'b1, 32'h0},        // R5 fresh line cleared
        {2'd0, 32'h1AC, 32'h0,        2'd3, 1'b0, 32'h0},        // R8 idle
        {2'd2, 32'h0AC, 32'h0,        2'd3, 1'b0, 32'h0},        // R3 set 5, tag 0
        {2'd2, 32'h20C, 32'h0,        2'd3, 1'b1, 32'h0}         // R5 word 3 cleared
    };
    string vreq [NV] = '{"R1","R8","R4","R6","R6","R6","R7","R7","R7","R4","R4","R4",
                         "R3","R5","R5","R5","R5","R2","R2","R2","R5","R8","R3","R5"};

    // Compare outputs against expectation and log failures
    task automatic check(input string req, input logic eh, input logic [31:0] ed);
        n_checks++;
        if (hit !== eh || rdata !== ed) begin
            n_errors++;
            $display("FAIL %s: hit=%0b data=%h expected hit=%0b data=%h", req, hit, rdata, eh, ed);
        end
    endtask

    // Drive one cycle of inputs, then return at the next falling edge
    task automatic step(input logic w, input logic r, input logic [31:0] a,
                        input logic [31:0] d, input logic [1:0] sz);
        wr_en = w; rd_en = r; addr = a; wdata = d; size = sz;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 32'h0); // outputs quiet during reset
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [100:0] v;
            v = VEC[i];
            step(v[99], v[100], v[98:67], v[66:35], v[34:33]);
            check(vreq[i], v[32], v[31:0]);
        end

        // R9: read paired with write sees the line before the write
        step(1'b1, 1'b1, 32'h308, 32'h12345678, 2'd3);
        check("R9", 1'b0, 32'h0);
        step(1'b0, 1'b1, 32'h308, 32'h0, 2'd3);
        check("R9", 1'b1, 32'h12345678);
        step(1'b1, 1'b1, 32'h308, 32'h9999AAAA, 2'd3);
        check("R9", 1'b1, 32'h12345678);
        step(1'b0, 1'b1, 32'h308, 32'h0, 2'd3);
        check("R9", 1'b1, 32'h9999AAAA);

        // R1: reset mid-run invalidates lines
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 32'h308, 32'h0, 2'd3);
        check("R1", 1'b0, 32'h0);
        step(1'b0, 1'b1, 32'h1AC, 32'h0, 2'd3);
        check("R1", 1'b0, 32'h0);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule